// File: doc/BRIEF.md
# Message Padder and 512-bit Blocker

This unit sits in front of a compression function that consumes 512-bit blocks. It takes a message one byte per accepted beat and packs the bytes into 512-bit blocks. The first byte of a block goes in the most significant byte. When the message ends, it applies length-strengthened padding. A single one bit, written as the byte 0x80, follows the last message byte. Zero bytes then fill until the padded length is 256 modulo 512 bits. The last 256 bits carry the total message length in bits.

Both sides use a valid/ready handshake. The input side carries a last flag, plus an empty flag for a final beat that holds no byte. The output side marks the block that carries the length field as final. A 256-bit counter tracks the message length in bits. When the tail of the message leaves no room for the 0x80 byte plus the 32-byte length field, the unit sends one more block. While a block is waiting on the output, and while that extra block is being sent, the input is stalled.

Top module: `msg_pad_blocker`

## Requirements
- R1: Every output block is 512 bits wide. Message bytes fill it from bits [511:504] downward in arrival order, byte k of a block at bits [511-8k -: 8].
- R2: The byte 0x80 is placed in the byte position directly after the last message byte, counted over the whole message.
- R3: All bytes between the 0x80 byte and the length field are zero. The low 256 bits of the final block hold the message length in bits (8 times the byte count), right-justified and unsigned.
- R4: When the last block holds 31 or fewer message bytes, that block carries 0x80, the zeros and the length, and it is the only block sent after the last beat.
- R5: When the last block holds 32 to 63 message bytes, it is sent with 0x80 and zero fill and out_final low. One more block follows: all zeros except the length field, with out_final high.
- R6: When the message length is a nonzero multiple of 64 bytes, the last data block is sent unchanged with out_final low. It is followed by a block with 0x80 in bits [511:504], zeros, and the length field, with out_final high.
- R7: A zero-length message is given as a single beat with in_last and in_empty both high. It yields exactly one final block: 0x80 in the top byte, zeros elsewhere, and a length field of zero.
- R8: in_ready is low whenever out_valid is high. After reset, in_ready is high and out_valid is low. While out_valid is high and out_ready is low, out_block and out_final hold their values.
- R9: The length count restarts at zero for each message, so a message's length field does not depend on any earlier message.
- R10: out_final is high only on the last block of a message, the one that holds the length field.
- R11: The cycle after a beat with in_last is accepted, out_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Unit accepts an input beat |
| in_data | input | 8 | Message byte |
| in_last | input | 1 | Beat ends the message |
| in_empty | input | 1 | With in_last: the beat carries no byte |
| out_valid | output | 1 | Output block valid |
| out_ready | input | 1 | Consumer accepts the block |
| out_block | output | 512 | Padded message block |
| out_final | output | 1 | Block carries the length field |

## Verification
The properties assume that in_empty is raised only together with in_last. They also assume that a message stays far below 2^256 bits, so the length counter never wraps. The properties do not rely on out_ready being held steady. The stimulus raises in_empty only on the single beat of a zero-length message and keeps every message to a few hundred bytes. The stimulus toggles out_ready and in_valid in fixed rhythms, so stalls land on waiting blocks, on extra blocks and on input gaps.

// File: rtl/mpb_pkg.sv
// Shared types for the message padder.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package mpb_pkg;

    // Controller phases: collecting bytes, showing a block, showing the extra pad block.
    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_EXTRA = 2'd2
    } mpb_state_e;

endpackage

// File: rtl/mpb_len_ctr.sv
// Message length counter in bits.
// Adds STEP once per stored byte and returns to zero when the final block of a
// message leaves. Assumes inc and clr are never raised in the same cycle.
module mpb_len_ctr #(
    parameter int LEN_W = 256,
    parameter int STEP  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [LEN_W-1:0] len
);

    // Accumulate the bit count and clear it at message end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            len <= '0;
        end else if (inc) begin
            len <= len + LEN_W'(STEP);
        end
    end

endmodule

// File: rtl/mpb_lane_buf.sv
// Block assembly buffer made of byte lanes.
// Lane 0 is the most significant byte of the block. In one cycle a lane may
// take a data byte or the pad byte. All lanes return to zero when a block
// leaves, so zero fill costs no extra cycles. seed_top loads the pad byte into
// lane 0 during that clear.
// Assumes wr_idx and pad_idx never point at the same lane in one cycle. An
// index equal to LANES selects no lane.
module mpb_lane_buf #(
    parameter int LANES  = 64,
    parameter int BYTE_W = 8,
    parameter int IDX_W  = $clog2(LANES) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [BYTE_W-1:0]       wr_byte,
    input  logic                    pad_en,
    input  logic [IDX_W-1:0]        pad_idx,
    input  logic                    clr,
    input  logic                    seed_top,
    output logic [LANES*BYTE_W-1:0] blk
);

    localparam logic [BYTE_W-1:0] PAD_BYTE = BYTE_W'(1) << (BYTE_W - 1);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;

        // Per-lane update: clear or seed, data write, pad write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (clr) begin
                lane_q <= (g == 0 && seed_top) ? PAD_BYTE : '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                lane_q <= wr_byte;
            end else if (pad_en && pad_idx == IDX_W'(g)) begin
                lane_q <= PAD_BYTE;
            end
        end

        assign blk[(LANES-g)*BYTE_W-1 -: BYTE_W] = lane_q;
    end

endmodule

// File: rtl/mpb_ctrl.sv
// Sequencing for the message padder.
// Tracks the byte position inside the current block and decides where the
// pad byte goes. It chooses between one final block, a padded block followed
// by an extra length block, or a full data block followed by an extra block
// that starts with the pad byte. It also drives both handshakes.
// Assumes in_empty is raised only together with in_last.
module mpb_ctrl
    import mpb_pkg::*;
#(
    parameter int LANES     = 64,
    parameter int LEN_BYTES = 32,
    parameter int CNT_W     = $clog2(LANES),
    parameter int IDX_W     = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic             in_empty,
    output logic             in_ready,
    input  logic             out_ready,
    output logic             out_valid,
    output logic             out_final,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             pad_en,
    output logic [IDX_W-1:0] pad_idx,
    output logic             blk_clr,
    output logic             seed_top,
    output logic             len_inc,
    output logic             len_clr
);

    localparam logic [CNT_W-1:0] LAST_LANE = CNT_W'(LANES - 1);
    localparam logic [IDX_W-1:0] FIT_LIMIT = IDX_W'(LANES - LEN_BYTES);
    localparam logic [IDX_W-1:0] NO_LANE   = IDX_W'(LANES);

    mpb_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             hold_final;
    logic             need_extra;
    logic             extra_lead;

    logic             accept;
    logic             has_byte;
    logic [IDX_W-1:0] pad_pos;
    logic             fits;

    // Beat decode: byte present, pad position, room check for the length field.
    always_comb begin
        accept   = in_valid && (state == ST_FILL);
        has_byte = !(in_last && in_empty);
        pad_pos  = {1'b0, cnt} + IDX_W'(has_byte);
        fits     = pad_pos < FIT_LIMIT;
    end

    // Handshake and datapath control outputs.
    always_comb begin
        in_ready  = (state == ST_FILL);
        out_valid = (state != ST_FILL);
        out_final = (state == ST_EXTRA) || (state == ST_HOLD && hold_final);
        wr_en     = accept && has_byte;
        wr_idx    = {1'b0, cnt};
        pad_en    = accept && in_last;
        pad_idx   = pad_pos;
        blk_clr   = out_valid && out_ready;
        seed_top  = (state == ST_HOLD) && need_extra && extra_lead;
        len_inc   = wr_en;
        len_clr   = blk_clr && out_final;
    end

    // Phase register, byte position and end-of-message plan.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_FILL;
            cnt        <= '0;
            hold_final <= 1'b0;
            need_extra <= 1'b0;
            extra_lead <= 1'b0;
        end else begin
            case (state)
                ST_FILL: begin
                    if (accept) begin
                        if (in_last) begin
                            state      <= ST_HOLD;
                            cnt        <= '0;
                            hold_final <= fits;
                            need_extra <= !fits;
                            extra_lead <= (pad_pos == NO_LANE);
                        end else if (cnt == LAST_LANE) begin
                            state      <= ST_HOLD;
                            cnt        <= '0;
                            hold_final <= 1'b0;
                            need_extra <= 1'b0;
                            extra_lead <= 1'b0;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                ST_HOLD: begin
                    if (out_ready) begin
                        state <= need_extra ? ST_EXTRA : ST_FILL;
                    end
                end
                ST_EXTRA: begin
                    if (out_ready) begin
                        state      <= ST_FILL;
                        need_extra <= 1'b0;
                    end
                end
                default: state <= ST_FILL;
            endcase
        end
    end

endmodule

// File: rtl/msg_pad_blocker.sv
// Message padder and 512-bit blocker (top).
// Packs a byte stream into BLOCK_W-bit blocks, most significant byte first.
// It applies a one bit, zero fill and a LEN_W-bit length field, and sends an
// extra block when the tail has no room for the pad. On the final block the
// length field is muxed into the low LEN_W bits; the buffer lanes there are
// zero at that point.
// Assumes in_empty only with in_last, and messages shorter than 2^LEN_W bits.
module msg_pad_blocker #(
    parameter int BLOCK_W = 512,
    parameter int BYTE_W  = 8,
    parameter int LEN_W   = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [BYTE_W-1:0]  in_data,
    input  logic               in_last,
    input  logic               in_empty,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [BLOCK_W-1:0] out_block,
    output logic               out_final
);

    localparam int LANES     = BLOCK_W / BYTE_W;
    localparam int LEN_BYTES = LEN_W / BYTE_W;
    localparam int IDX_W     = $clog2(LANES) + 1;

    logic               wr_en;
    logic [IDX_W-1:0]   wr_idx;
    logic               pad_en;
    logic [IDX_W-1:0]   pad_idx;
    logic               blk_clr;
    logic               seed_top;
    logic               len_inc;
    logic               len_clr;
    logic [BLOCK_W-1:0] blk;
    logic [LEN_W-1:0]   len_bits;

    mpb_ctrl #(
        .LANES     (LANES),
        .LEN_BYTES (LEN_BYTES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_empty  (in_empty),
        .in_ready  (in_ready),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_final (out_final),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .pad_en    (pad_en),
        .pad_idx   (pad_idx),
        .blk_clr   (blk_clr),
        .seed_top  (seed_top),
        .len_inc   (len_inc),
        .len_clr   (len_clr)
    );

    mpb_lane_buf #(
        .LANES  (LANES),
        .BYTE_W (BYTE_W),
        .IDX_W  (IDX_W)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_byte  (in_data),
        .pad_en   (pad_en),
        .pad_idx  (pad_idx),
        .clr      (blk_clr),
        .seed_top (seed_top),
        .blk      (blk)
    );

    mpb_len_ctr #(
        .LEN_W (LEN_W),
        .STEP  (BYTE_W)
    ) u_len (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (len_inc),
        .clr   (len_clr),
        .len   (len_bits)
    );

    // Output block: the length field replaces the low lanes on the final block.
    always_comb begin
        out_block = out_final ? {blk[BLOCK_W-1:LEN_W], len_bits} : blk;
    end

endmodule

// File: rtl/mpb_checker.sv
// Protocol properties for the message padder, bound to the top module.
// Assumes in_empty only with in_last and no length counter wrap.
module mpb_checker #(
    parameter int BLOCK_W = 512,
    parameter int BYTE_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic               in_last,
    input logic               out_valid,
    input logic               out_ready,
    input logic               out_final,
    input logic [BLOCK_W-1:0] out_block
);

    localparam int LB = $clog2(BYTE_W);

    // R8: input is stalled while a block is shown.
    p_ready_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R8: a block that is not taken stays unchanged.
    p_block_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_block) && $stable(out_final)));

    // R3: the length field counts whole bytes, so its low bits are zero.
    p_len_whole_bytes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_final) |-> (out_block[LB-1:0] == '0));

    // R11: a block appears the cycle after the last beat is taken.
    p_last_to_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> out_valid);

endmodule

bind msg_pad_blocker mpb_checker #(
    .BLOCK_W (BLOCK_W),
    .BYTE_W  (BYTE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_final (out_final),
    .out_block (out_block)
);

// File: tb/msg_pad_blocker_tb.sv
`timescale 1ns/1ps
// Directed bench for the message padder: one task per scenario, with the
// expected padded stream computed from the requirements.
module msg_pad_blocker_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [7:0]   in_data = '0;
    logic         in_last = 1'b0;
    logic         in_empty = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [511:0] out_block;
    logic         out_final;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    msg_pad_blocker u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_empty  (in_empty),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_block (out_block),
        .out_final (out_final)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] msg_byte(input int i, input int seed);
        return 8'((i * 13 + seed * 7 + 1) & 255);
    endfunction

    // Padded length in bytes: message, 0x80, zeros to 32 mod 64, 32-byte length.
    function automatic int padded_len(input int n);
        int t = n + 1;
        while ((t % 64) != 32) t++;
        return t + 32;
    endfunction

    // Expected block k of the padded stream.
    function automatic logic [511:0] exp_block(input int n, input int seed, input int k);
        logic [511:0] b = '0;
        int total = padded_len(n);
        int lenbits = n * 8;
        for (int p = 0; p < 64; p++) begin
            int j = k * 64 + p;
            int e = total - 1 - j;
            logic [7:0] v;
            if (j < n)            v = msg_byte(j, seed);
            else if (j == n)      v = 8'h80;
            else if (e < 4)       v = 8'((lenbits >> (8 * e)) & 255);
            else                  v = 8'h00;
            b[511 - 8*p -: 8] = v;
        end
        return b;
    endfunction

    // Send one message of n bytes (n = 0 uses the empty flag) and check every block.
    task automatic run_msg(input int n, input int seed, input bit stall, input string req);
        int beats = (n == 0) ? 1 : n;
        int nblk = padded_len(n) / 64;
        int sent = 0;
        int blk_i = 0;
        int cyc = 0;
        bit last_acc = 1'b0;
        bit prev_stall = 1'b0;
        logic [511:0] prev_blk = '0;
        logic prev_fin = 1'b0;
        while (blk_i < nblk && cyc < 4000) begin
            @(negedge clk);
            if (last_acc) begin
                check(out_valid == 1'b1, "R11", "valid after last beat",
                      512'(out_valid), 512'(1));
                last_acc = 1'b0;
            end
            if (prev_stall) begin
                check(out_block == prev_blk && out_final == prev_fin, "R8",
                      "block held under stall", out_block, prev_blk);
            end
            if (out_valid) begin
                check(in_ready == 1'b0, "R8", "ready low while block shown",
                      512'(in_ready), 512'(0));
            end
            in_valid  = (sent < beats) && (!stall || (cyc % 5) != 2);
            in_data   = (n == 0) ? 8'h00 : msg_byte(sent, seed);
            in_last   = (sent == beats - 1);
            in_empty  = (n == 0);
            out_ready = !stall || (cyc % 3) != 0;
            if (in_valid && in_ready) begin
                if (in_last) last_acc = 1'b1;
                sent++;
            end
            if (out_valid && out_ready) begin
                check(out_block == exp_block(n, seed, blk_i), req, "block contents",
                      out_block, exp_block(n, seed, blk_i));
                check(out_final == (blk_i == nblk - 1), "R10", "final flag",
                      512'(out_final), 512'(blk_i == nblk - 1));
                blk_i++;
            end
            prev_stall = out_valid && !out_ready;
            prev_blk   = out_block;
            prev_fin   = out_final;
            cyc++;
        end
        @(negedge clk);
        in_valid  = 1'b0;
        in_last   = 1'b0;
        in_empty  = 1'b0;
        out_ready = 1'b0;
        check(blk_i == nblk, req, "block count", 512'(blk_i), 512'(nblk));
        check(out_valid == 1'b0, req, "no block beyond the last", 512'(out_valid), 512'(0));
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state of the handshakes.
        check(in_ready == 1'b1 && out_valid == 1'b0, "R8", "reset handshake",
              512'({in_ready, out_valid}), 512'(2'b10));
    endtask

    task automatic test_back_to_back();
        // R9: a second message must not inherit the first length.
        run_msg(100, 4, 1'b0, "R9");
        run_msg(5, 9, 1'b0, "R9");
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        test_reset();
        run_msg(3, 1, 1'b0, "R1");    // R1: byte placement
        run_msg(17, 2, 1'b0, "R2");   // R2: pad byte position
        run_msg(20, 3, 1'b1, "R3");   // R3: zero fill and length field
        run_msg(31, 5, 1'b0, "R4");   // R4: boundary of the single block case
        run_msg(32, 6, 1'b0, "R5");   // R5: smallest tail needing an extra block
        run_msg(63, 7, 1'b1, "R5");   // R5: pad in the last lane
        run_msg(64, 8, 1'b0, "R6");   // R6: exact block multiple
        run_msg(128, 10, 1'b1, "R6"); // R6: two full blocks under stalls
        run_msg(0, 0, 1'b0, "R7");    // R7: empty message
        run_msg(130, 11, 1'b1, "R8"); // R8: multi-block with backpressure
        test_back_to_back();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule